// File: doc/BRIEF.md
# Hop-Level Flit Retransmission Link

This block models one switch-to-switch hop of an on-chip network in which every flit is protected on its own. The upstream side writes each incoming flit into a circular retransmission store, appends a CRC-8 check value and a sequence tag, and sends it across a link that is a chain of NL pipeline registers. The downstream side recomputes the check value. It answers each flit in order with an acknowledge, or with a negative acknowledge when the check fails. Flits that are accepted go into a queuing buffer, and the local sink drains that buffer. Credits for queue slots travel back over their own NL-cycle path.

The response travels upstream as three identical copies, and a bitwise majority vote resolves them, so a fault on one copy is masked. On a negative acknowledge the sender rewinds to the oldest unacknowledged flit and sends it again, followed by every later flit still held (go-back-N). The receiver drops every flit that does not carry the expected sequence tag, which keeps delivery in order and free of duplicates. While the receiver waits for a resent copy it repeats its negative acknowledge on a timeout, so a resent copy that is itself corrupted is still recovered. Two inputs let a test environment disturb the channel: one inverts payload bit 0 of the flit entering the link, and one inverts chosen copies of the response line.

Top module: `hop_retx_link`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: Without channel faults, the sequence of flits handed out at out_flit equals the sequence accepted at in_flit, with no loss, duplication or change.
- R3: On an idle, empty link, a flit accepted at clock edge k first shows out_valid high after edge k+NL+1.
- R4: With the sink always ready and no faults, in_ready stays high through an unbroken burst of input flits.
- R5: The check value is CRC-8 with polynomial 0x07, initial value 0, fed MSB first over the payload. Inverting payload bit 0 of any flit on the link (link_flip) is detected, and that flit is resent. The output stream still equals the input stream.
- R6: After a failed flit, flits with any other sequence tag are discarded until the expected one arrives intact, so no flit is delivered twice or out of order.
- R7: Inverting any single copy of the triplicated response line in any cycle (ack_flip with at most one bit set) has no effect: the stream stays intact and throughput is unchanged.
- R8: While out_ready is low, out_valid and out_flit hold steady. Exactly 2*(2*NL+1) flits are accepted before in_ready falls, one store's worth and one queue's worth, and all of them are delivered once the sink resumes.
- R9: When corruption lasts longer than one round trip, the receiver repeats its negative acknowledge every 2*NL+4 cycles of waiting. Delivery completes once the channel is clean again.
- R10: The sender never has more flits outstanding than the queue has slots (2*NL+1), and the retransmission store never holds more than 2*NL+1 flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Upstream offers a flit |
| in_flit | input | DW | Offered flit payload |
| in_ready | output | 1 | Retransmission store can take the flit this cycle |
| out_valid | output | 1 | Queuing buffer holds a flit for the sink |
| out_flit | output | DW | Flit at the head of the queuing buffer |
| out_ready | input | 1 | Sink takes the head flit |
| link_flip | input | 1 | Invert payload bit 0 of the flit entering the link this cycle |
| ack_flip | input | 3 | Invert the selected copies of the response entering the return path |

## Verification
The bench corrupts flits in the middle of a streaming burst. A receiver that failed to discard the flits following a bad one would deliver duplicates or reorder the stream, and a sender that rewound to the wrong place would lose a flit. A corruption window longer than the round trip also hits the resent copies. Without the timeout re-nack the run would hang and the drain check would report it. A single inverted response copy every cycle catches a broken voter, which would produce stray rewinds, stalls or lost acknowledges. The stalled-sink scenario counts how many flits are accepted, which exposes a credit counter or store depth that is off by one and any flit dropped under back-pressure.

// File: rtl/hrl_pkg.sv
package hrl_pkg;
    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_ACK  = 2'b01,
        RSP_NACK = 2'b10
    } rsp_t;
endpackage

// File: rtl/hrl_crc8.sv
module hrl_crc8 #(
    parameter int DW = 64
) (
    input  logic [DW-1:0]             data,
    output logic [hrl_pkg::CRC_W-1:0] crc
);
    import hrl_pkg::*;

    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        crc = acc;
    end
endmodule

// File: rtl/hrl_pipe.sv
module hrl_pipe #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [N];
    logic [W-1:0] stg_q [N];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < N; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[N-1];
endmodule

// File: rtl/hrl_vote.sv
module hrl_vote #(
    parameter int W = 2
) (
    input  logic [W-1:0] copy_a,
    input  logic [W-1:0] copy_b,
    input  logic [W-1:0] copy_c,
    output logic [W-1:0] voted
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            assign voted[b] = (copy_a[b] & copy_b[b]) | (copy_a[b] & copy_c[b]) |
                              (copy_b[b] & copy_c[b]);
        end
    endgenerate
endmodule

// File: rtl/hrl_tx.sv
module hrl_tx #(
    parameter int DW     = 64,
    parameter int DEPTH  = 5,
    parameter int QDEPTH = 5,
    parameter int SW     = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DW-1:0]             in_flit,
    output logic                      in_ready,
    input  logic [1:0]                rsp,
    input  logic [1:0]                cred_ret,
    output logic                      tx_valid,
    output logic [DW-1:0]             tx_flit,
    output logic [SW-1:0]             tx_seq,
    output logic [hrl_pkg::CRC_W-1:0] tx_crc
);
    import hrl_pkg::*;

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int KW = $clog2(QDEPTH + 3);

    typedef struct packed {
        logic [IW-1:0] head;
        logic [IW-1:0] wr;
        logic [CW-1:0] cnt;
        logic [CW-1:0] off;
        logic [KW-1:0] cred;
        logic [SW-1:0] wseq;
    } tx_state_t;

    tx_state_t st_q, st_d;

    logic [DW-1:0] flit_mem [DEPTH];
    logic [SW-1:0] seq_mem  [DEPTH];

    logic          got_ack, got_nack, push, send;
    logic [IW-1:0] snd_idx;

    function automatic logic [IW-1:0] idx_step(input logic [IW-1:0] v);
        return (int'(v) == DEPTH - 1) ? '0 : IW'(int'(v) + 1);
    endfunction

    always_comb begin
        int s;
        int o;
        got_ack  = (rsp == RSP_ACK);
        got_nack = (rsp == RSP_NACK);
        in_ready = (int'(st_q.cnt) < DEPTH) || got_ack;
        push     = in_valid && in_ready;

        s = int'(st_q.head) + int'(st_q.off);
        if (s >= DEPTH) s = s - DEPTH;
        snd_idx = IW'(s);

        send = !got_nack && (st_q.off < st_q.cnt) &&
               ((int'(st_q.cred) + int'(cred_ret)) > 0);

        st_d = st_q;
        if (got_ack) st_d.head = idx_step(st_q.head);
        if (push) begin
            st_d.wr   = idx_step(st_q.wr);
            st_d.wseq = st_q.wseq + 1'b1;
        end
        st_d.cnt  = CW'(int'(st_q.cnt) + (push ? 1 : 0) - (got_ack ? 1 : 0));
        st_d.cred = KW'(int'(st_q.cred) + int'(cred_ret) - (send ? 1 : 0));

        o = int'(st_q.off) + (send ? 1 : 0);
        if (got_ack && o > 0) o = o - 1;
        if (got_nack) o = 0;
        st_d.off = CW'(o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cred <= KW'(QDEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            flit_mem[st_q.wr] <= in_flit;
            seq_mem[st_q.wr]  <= st_q.wseq;
        end
    end

    assign tx_valid = send;
    assign tx_flit  = flit_mem[snd_idx];
    assign tx_seq   = seq_mem[snd_idx];

    hrl_crc8 #(.DW(DW)) u_crc (
        .data (tx_flit),
        .crc  (tx_crc)
    );
endmodule

// File: rtl/hrl_rx.sv
module hrl_rx #(
    parameter int DW     = 64,
    parameter int QDEPTH = 5,
    parameter int SW     = 5,
    parameter int TMO    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lk_valid,
    input  logic [DW-1:0]             lk_flit,
    input  logic [SW-1:0]             lk_seq,
    input  logic [hrl_pkg::CRC_W-1:0] lk_crc,
    output logic [1:0]                rsp,
    output logic [1:0]                cred_ret,
    output logic                      out_valid,
    output logic [DW-1:0]             out_flit,
    input  logic                      out_ready
);
    import hrl_pkg::*;

    localparam int QIW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int QCW = $clog2(QDEPTH + 1);
    localparam int TW  = $clog2(TMO + 1);

    typedef struct packed {
        logic [SW-1:0]  exp_seq;
        logic           waiting;
        logic [TW-1:0]  timer;
        logic [QIW-1:0] rd;
        logic [QIW-1:0] wr;
        logic [QCW-1:0] cnt;
    } rx_state_t;

    rx_state_t st_q, st_d;

    logic [DW-1:0] q_mem [QDEPTH];
    logic [hrl_pkg::CRC_W-1:0] calc_crc;
    logic bad, accept, discard, send_nack, pop;

    function automatic logic [QIW-1:0] q_step(input logic [QIW-1:0] v);
        return (int'(v) == QDEPTH - 1) ? '0 : QIW'(int'(v) + 1);
    endfunction

    hrl_crc8 #(.DW(DW)) u_chk (
        .data (lk_flit),
        .crc  (calc_crc)
    );

    always_comb begin
        bad       = lk_valid && (calc_crc != lk_crc);
        accept    = lk_valid && !bad && (lk_seq == st_q.exp_seq);
        discard   = lk_valid && !accept;
        send_nack = !accept &&
                    ((bad && !st_q.waiting) ||
                     (st_q.waiting && int'(st_q.timer) == TMO - 1));
        pop       = out_valid && out_ready;

        if (accept)         rsp = RSP_ACK;
        else if (send_nack) rsp = RSP_NACK;
        else                rsp = RSP_NONE;

        cred_ret = 2'(int'(pop) + int'(discard));

        st_d = st_q;
        if (accept) begin
            st_d.exp_seq = st_q.exp_seq + 1'b1;
            st_d.waiting = 1'b0;
            st_d.timer   = '0;
            st_d.wr      = q_step(st_q.wr);
        end else if (send_nack) begin
            st_d.waiting = 1'b1;
            st_d.timer   = '0;
        end else if (st_q.waiting) begin
            st_d.timer   = st_q.timer + 1'b1;
        end
        if (pop) st_d.rd = q_step(st_q.rd);
        st_d.cnt = QCW'(int'(st_q.cnt) + (accept ? 1 : 0) - (pop ? 1 : 0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) q_mem[st_q.wr] <= lk_flit;
    end

    assign out_valid = (st_q.cnt != '0);
    assign out_flit  = q_mem[st_q.rd];
endmodule

// File: rtl/hop_retx_link.sv
module hop_retx_link #(
    parameter int DW = 64,
    parameter int NL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_flit,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_flit,
    input  logic          out_ready,
    input  logic          link_flip,
    input  logic [2:0]    ack_flip
);
    import hrl_pkg::*;

    localparam int DEPTH  = 2 * NL + 1;
    localparam int QDEPTH = 2 * NL + 1;
    localparam int SW     = $clog2(DEPTH) + 2;
    localparam int TMO    = 2 * NL + 4;
    localparam int LW     = 1 + SW + CRC_W + DW;

    logic              tx_valid;
    logic [DW-1:0]     tx_flit;
    logic [SW-1:0]     tx_seq;
    logic [CRC_W-1:0]  tx_crc;
    logic [DW-1:0]     flip_mask;
    logic [LW-1:0]     fwd_in, fwd_out;
    logic              lk_valid;
    logic [DW-1:0]     lk_flit;
    logic [SW-1:0]     lk_seq;
    logic [CRC_W-1:0]  lk_crc;
    logic [1:0]        rx_rsp;
    logic [1:0]        rx_cred;
    logic [1:0]        cred_back;
    logic [1:0]        rsp_copy [3];
    logic [1:0]        rsp_voted;

    hrl_tx #(.DW(DW), .DEPTH(DEPTH), .QDEPTH(QDEPTH), .SW(SW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_flit  (in_flit),
        .in_ready (in_ready),
        .rsp      (rsp_voted),
        .cred_ret (cred_back),
        .tx_valid (tx_valid),
        .tx_flit  (tx_flit),
        .tx_seq   (tx_seq),
        .tx_crc   (tx_crc)
    );

    assign flip_mask = {{(DW-1){1'b0}}, link_flip};
    assign fwd_in    = {tx_valid, tx_seq, tx_crc, tx_flit ^ flip_mask};

    hrl_pipe #(.W(LW), .N(NL)) u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (fwd_in),
        .q     (fwd_out)
    );

    assign {lk_valid, lk_seq, lk_crc, lk_flit} = fwd_out;

    hrl_rx #(.DW(DW), .QDEPTH(QDEPTH), .SW(SW), .TMO(TMO)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_flit   (lk_flit),
        .lk_seq    (lk_seq),
        .lk_crc    (lk_crc),
        .rsp       (rx_rsp),
        .cred_ret  (rx_cred),
        .out_valid (out_valid),
        .out_flit  (out_flit),
        .out_ready (out_ready)
    );

    hrl_pipe #(.W(2), .N(NL)) u_cred (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_cred),
        .q     (cred_back)
    );

    genvar c;
    generate
        for (c = 0; c < 3; c++) begin : g_rsp
            hrl_pipe #(.W(2), .N(NL)) u_rsp (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (rx_rsp ^ {2{ack_flip[c]}}),
                .q     (rsp_copy[c])
            );
        end
    endgenerate

    hrl_vote #(.W(2)) u_vote (
        .copy_a (rsp_copy[0]),
        .copy_b (rsp_copy[1]),
        .copy_c (rsp_copy[2]),
        .voted  (rsp_voted)
    );
endmodule

// File: rtl/hop_retx_link_chk.sv
module hop_retx_link_chk #(
    parameter int DW = 64,
    parameter int NL = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_flit,
    input logic          tx_valid,
    input logic [1:0]    cred_back,
    input logic [1:0]    rsp_voted
);
    localparam int SLOTS = 2 * NL + 1;

    int credit_out_q;
    int held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            credit_out_q <= 0;
            held_q       <= 0;
        end else begin
            credit_out_q <= credit_out_q + int'(tx_valid) - int'(cred_back);
            held_q       <= held_q + int'(in_valid && in_ready) -
                            int'(rsp_voted == 2'b01);
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_flit));

    // R7
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_voted));

    // R10
    credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        credit_out_q <= SLOTS && credit_out_q >= 0);

    // R10
    store_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= SLOTS && held_q >= 0);
endmodule

bind hop_retx_link hop_retx_link_chk #(.DW(DW), .NL(NL)) u_link_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_flit  (out_flit),
    .tx_valid  (tx_valid),
    .cred_back (cred_back),
    .rsp_voted (rsp_voted)
);

// File: tb/hop_retx_link_tb.sv
module hop_retx_link_tb;
    localparam int DW       = 64;
    localparam int NL       = 2;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_flit = '0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_flit;
    logic          out_ready = 1'b1;
    logic          link_flip = 1'b0;
    logic [2:0]    ack_flip = 3'b000;

    int checks = 0;
    int fails  = 0;
    int wr_n   = 0;
    int rd_n   = 0;
    int cyc    = 0;
    int seed_n = 0;
    logic [DW-1:0] exp_q [0:1023];

    hop_retx_link #(.DW(DW), .NL(NL)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_flit   (in_flit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_flit  (out_flit),
        .out_ready (out_ready),
        .link_flip (link_flip),
        .ack_flip  (ack_flip)
    );

    always #(CLK_PER / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] mk(input int i);
        return (64'(i) * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0F0F_1234_A5A5_0001;
    endfunction

    // R2 R6: every delivered flit must be the next one accepted
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            checks++;
            if (rd_n >= wr_n) begin
                fails++;
                $display("FAIL R6 extra flit: actual %0h expected none", out_flit);
            end else begin
                if (out_flit !== exp_q[rd_n[9:0]]) begin
                    fails++;
                    $display("FAIL R2 flit %0d: actual %0h expected %0h",
                             rd_n, out_flit, exp_q[rd_n[9:0]]);
                end
                rd_n++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // called just after a negedge; returns just after a later negedge
    task automatic push_one(input logic [DW-1:0] v, inout int waits);
        in_valid = 1'b1;
        in_flit  = v;
        while (!in_ready) begin
            waits++;
            @(negedge clk);
        end
        exp_q[wr_n[9:0]] = v;
        wr_n++;
        @(negedge clk);
    endtask

    task automatic burst(input int n, output int waits);
        waits = 0;
        for (int i = 0; i < n; i++) begin
            push_one(mk(seed_n), waits);
            seed_n++;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (rd_n != wr_n && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(rd_n == wr_n, tag, "all flits delivered", rd_n, wr_n);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_latency;
        int w = 0;
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_flit   = mk(seed_n);
        chk(in_ready == 1'b1, "R3", "ready on idle link", in_ready, 1);
        exp_q[wr_n[9:0]] = in_flit;
        wr_n++;
        seed_n++;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (NL) @(negedge clk);
        chk(out_valid == 1'b0, "R3", "out_valid one cycle early", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R3", "out_valid at NL+1", out_valid, 1);
        drain("R3");
        w = 0;
    endtask

    task automatic t_stream;
        int w;
        out_ready = 1'b1;
        burst(24, w);
        chk(w == 0, "R4", "stall cycles in clean burst", w, 0);
        drain("R2");
    endtask

    task automatic t_single_error;
        int w;
        out_ready = 1'b1;
        fork
            burst(20, w);
            begin
                repeat (6) @(negedge clk);
                link_flip = 1'b1;
                @(negedge clk);
                link_flip = 1'b0;
            end
        join
        drain("R5");
        fork
            burst(12, w);
            begin
                repeat (3) @(negedge clk);
                link_flip = 1'b1;
                @(negedge clk);
                link_flip = 1'b0;
                repeat (2) @(negedge clk);
                link_flip = 1'b1;
                @(negedge clk);
                link_flip = 1'b0;
            end
        join
        drain("R6");
    endtask

    task automatic t_ack_faults;
        int w;
        out_ready = 1'b1;
        fork
            burst(30, w);
            begin
                for (int i = 0; i < 45; i++) begin
                    ack_flip = 3'b001 << (i % 3);
                    @(negedge clk);
                end
                ack_flip = 3'b000;
            end
        join
        chk(w == 0, "R7", "stall cycles with one bad copy", w, 0);
        drain("R7");
    endtask

    task automatic t_stall;
        int acc = 0;
        logic [DW-1:0] first_v;
        first_v   = mk(seed_n);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        for (int i = 0; i < 40; i++) begin
            in_flit = mk(seed_n);
            if (in_ready) begin
                exp_q[wr_n[9:0]] = in_flit;
                wr_n++;
                seed_n++;
                acc++;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(acc == 2 * (2 * NL + 1), "R8", "flits accepted while stalled (R10)",
            acc, 2 * (2 * NL + 1));
        chk(in_ready == 1'b0, "R10", "in_ready when full", in_ready, 0);
        chk(out_valid == 1'b1, "R8", "out_valid held", out_valid, 1);
        chk(out_flit == first_v, "R8", "head flit held", out_flit, first_v);
        out_ready = 1'b1;
        drain("R8");
    endtask

    task automatic t_long_error;
        int w;
        out_ready = 1'b1;
        fork
            burst(16, w);
            begin
                repeat (4) @(negedge clk);
                link_flip = 1'b1;
                repeat (2 * NL + 10) @(negedge clk);
                link_flip = 1'b0;
            end
        join
        drain("R9");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_stream();
        t_single_error();
        t_ack_faults();
        t_stall();
        t_long_error();
        t_stream();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule